// File: doc/BRIEF.md
# Double-Buffered Transmit Gate Sequencer

This block drives the per-priority transmit gate of one switch port from a programmed list of gate commands. Each command pairs an 8-bit mask of priorities allowed to send with a duration measured in clock ticks. The commands live in a command store split into two banks. A periodic cycle-start pulse from an external timer restarts the list at slot 0 of the selected bank. The sequencer then walks the list, holding each mask for its programmed duration.

Software rewrites the bank that is not in use and then flips the bank select. The flip takes effect only at the next cycle start, and a status bit shows which bank is active. Software treats the swap as done once that bit matches the select it wrote. In single-buffer mode the select is ignored and bank 0 is always used. Gating applies only when both the global and the port enable are set. Otherwise every priority is allowed to send.

The state machine has four states. IDLE opens every gate. RUN counts down the current entry. HOLD keeps a zero-duration entry's mask in force. END keeps the last mask after the bank runs out. The transitions are:
- start: IDLE to RUN or HOLD on an enabled cycle start.
- advance: RUN to RUN or HOLD when an entry expires.
- overrun: RUN to END when slot 63 expires.
- restart: RUN, HOLD or END to RUN or HOLD on a cycle start.
- disable: any state to IDLE when either enable is low.

Top module: `gate_sequencer`

## Requirements
- R1: A command word carries the allow mask in bits 7:0 and the duration count in bits 21:8. The write address uses bit 6 to pick the bank and bits 5:0 to pick the slot.
- R2: While global_en or port_en is low, gate_mask is 8'hFF, cycle_start has no effect and active_bank keeps its value. After enabling, gate_mask stays 8'hFF until the first cycle start.
- R3: On an enabled cycle start, the slot-0 mask of the selected bank appears on gate_mask after that clock edge.
- R4: An entry with a nonzero count N keeps its mask for exactly N clocks. The next slot's mask then appears on the following edge.
- R5: An entry with count 0 keeps its mask until the next cycle start, and later slots are not used.
- R6: If slot 63 expires before a cycle start arrives, its mask is held and addr_err is set.
- R7: A cycle start that arrives while an entry is still counting cuts that entry short and restarts at slot 0.
- R8: A new bank_sel value is copied into active_bank only at an enabled cycle start. The sequencer reads from the bank that active_bank shows.
- R9: With single_buf high, every cycle start selects bank 0, whatever bank_sel holds.
- R10: Loading an entry whose count lies in 1..MIN_CNT-1 (default 16) sets cnt_err from the next edge on. The entry still lasts its programmed count.
- R11: Both error flags clear at each enabled cycle start. The exception is a flag that the slot-0 load made at that same start sets again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| global_en | input | 1 | Switch-wide gating enable |
| port_en | input | 1 | Per-port gating enable |
| single_buf | input | 1 | Forces bank 0 when high |
| bank_sel | input | 1 | Bank requested by software |
| cycle_start | input | 1 | One-clock cycle-start pulse from the timer |
| wr_en | input | 1 | Command store write strobe |
| wr_addr | input | 7 | Command store write address: bank in bit 6, slot below it |
| wr_data | input | 22 | Command word: count in bits 21:8, mask in bits 7:0 |
| gate_mask | output | 8 | Per-priority transmit allow |
| active_bank | output | 1 | Bank currently in use |
| cnt_err | output | 1 | A too-short nonzero count was loaded this cycle |
| addr_err | output | 1 | The bank ran out before the cycle ended |

## Verification
The assertions assume that cycle_start is a single-clock pulse and that reset is held across at least one clock edge. They also assume that software does not rewrite the active bank. The bench respects all three: it writes only the bank that is not in use, or writes while no cycle is running, and it raises cycle_start for exactly one clock each time. Expected masks and flags come from walking the bench's shadow copy of each bank and summing the durations for every elapsed clock.

// File: rtl/gcs_pkg.sv
package gcs_pkg;
    localparam int MASK_W = 8;
    localparam int CNT_W  = 14;
    localparam int CMD_W  = MASK_W + CNT_W;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [MASK_W-1:0] mask;
    } gcs_cmd_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_HOLD,
        ST_END
    } gcs_state_t;
endpackage

// File: rtl/gcs_cmd_store.sv
module gcs_cmd_store
    import gcs_pkg::*;
#(
    parameter int SLOTS = 64,
    localparam int DEPTH = 2 * SLOTS,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [CMD_W-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output gcs_cmd_t         rd_cmd
);
    logic [CMD_W-1:0] mem [DEPTH];

    // Software write port; no reset, contents are loaded before use.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Combinational read so a load lands on the same edge it is decided.
    assign rd_cmd = gcs_cmd_t'(mem[rd_addr]);
endmodule

// File: rtl/gcs_seq_fsm.sv
module gcs_seq_fsm
    import gcs_pkg::*;
#(
    parameter int SLOTS   = 64,
    parameter int MIN_CNT = 16,
    localparam int AW = $clog2(2 * SLOTS),
    localparam int SW = $clog2(SLOTS) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              single_buf,
    input  logic              bank_sel,
    input  logic              cycle_start,
    output logic [AW-1:0]     rd_addr,
    input  gcs_cmd_t          rd_cmd,
    output logic [MASK_W-1:0] mask_o,
    output logic              running,
    output logic              bank_act,
    output logic              cnt_err,
    output logic              addr_err
);
    gcs_state_t        state, state_n;
    logic [MASK_W-1:0] mask_r;
    logic [CNT_W-1:0]  cnt_r;
    logic [SW-1:0]     slot;
    logic [SW-1:0]     load_slot;
    logic              load_bank;
    logic              go;
    logic              at_end;
    logic              do_load;
    logic              end_hit;
    logic              short_cnt;

    assign go        = enable & cycle_start;
    assign load_bank = go ? (single_buf ? 1'b0 : bank_sel) : bank_act;
    assign load_slot = go ? '0 : slot;
    assign rd_addr   = {load_bank, load_slot[SW-2:0]};
    assign at_end    = (slot == SW'(SLOTS));
    assign short_cnt = (rd_cmd.cnt != '0) && (rd_cmd.cnt < CNT_W'(MIN_CNT));

    // Next-state and load decision
    always_comb begin
        state_n = state;
        do_load = 1'b0;
        end_hit = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (go) do_load = 1'b1;
            end
            ST_RUN: begin
                if (go) begin
                    do_load = 1'b1;
                end else if (cnt_r == CNT_W'(1)) begin
                    if (at_end) begin
                        end_hit = 1'b1;
                        state_n = ST_END;
                    end else begin
                        do_load = 1'b1;
                    end
                end
            end
            ST_HOLD, ST_END: begin
                if (go) do_load = 1'b1;
            end
            default: state_n = ST_IDLE;
        endcase
        if (do_load) begin
            state_n = (rd_cmd.cnt == '0) ? ST_HOLD : ST_RUN;
        end
        if (!enable) begin
            state_n = ST_IDLE;
            do_load = 1'b0;
            end_hit = 1'b0;
        end
    end

    // State register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            mask_r   <= '0;
            cnt_r    <= '0;
            slot     <= '0;
            bank_act <= 1'b0;
            cnt_err  <= 1'b0;
            addr_err <= 1'b0;
        end else begin
            state <= state_n;
            if (do_load) begin
                mask_r <= rd_cmd.mask;
                cnt_r  <= rd_cmd.cnt;
                slot   <= load_slot + SW'(1);
            end else if (state == ST_RUN) begin
                cnt_r <= cnt_r - CNT_W'(1);
            end
            if (go) begin
                bank_act <= load_bank;
            end
            cnt_err  <= (cnt_err & ~go) | (do_load & short_cnt);
            addr_err <= (addr_err & ~go) | end_hit;
        end
    end

    // Outputs
    always_comb begin
        mask_o  = mask_r;
        running = (state != ST_IDLE);
    end

    assert_bank_only_at_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_act != $past(bank_act)) |-> $past(go));

    assert_single_bank0_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (go && single_buf) |=> !bank_act);

    assert_restart_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> (slot == SW'(1)));

    assert_hold_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && enable && !cycle_start) |=> ($stable(mask_r) && state == ST_HOLD));

    assert_end_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_END) |-> addr_err);

    assert_run_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |-> (cnt_r != '0));

    assert_idle_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (state == ST_IDLE));
endmodule

// File: rtl/gate_sequencer.sv
module gate_sequencer
    import gcs_pkg::*;
#(
    parameter int SLOTS   = 64,
    parameter int MIN_CNT = 16,
    localparam int AW = $clog2(2 * SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              global_en,
    input  logic              port_en,
    input  logic              single_buf,
    input  logic              bank_sel,
    input  logic              cycle_start,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [CMD_W-1:0]  wr_data,
    output logic [MASK_W-1:0] gate_mask,
    output logic              active_bank,
    output logic              cnt_err,
    output logic              addr_err
);
    logic              enable;
    logic [AW-1:0]     rd_addr;
    gcs_cmd_t          rd_cmd;
    logic [MASK_W-1:0] seq_mask;
    logic              running;

    assign enable = global_en & port_en;

    gcs_cmd_store #(.SLOTS(SLOTS)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_cmd  (rd_cmd)
    );

    gcs_seq_fsm #(.SLOTS(SLOTS), .MIN_CNT(MIN_CNT)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .single_buf  (single_buf),
        .bank_sel    (bank_sel),
        .cycle_start (cycle_start),
        .rd_addr     (rd_addr),
        .rd_cmd      (rd_cmd),
        .mask_o      (seq_mask),
        .running     (running),
        .bank_act    (active_bank),
        .cnt_err     (cnt_err),
        .addr_err    (addr_err)
    );

    assign gate_mask = (enable && running) ? seq_mask : {MASK_W{1'b1}};
endmodule

// File: tb/sim_gate_sequencer.sv
module sim_gate_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        global_en = 1'b1;
    logic        port_en = 1'b1;
    logic        single_buf = 1'b0;
    logic        bank_sel = 1'b0;
    logic        cycle_start = 1'b0;
    logic        wr_en = 1'b0;
    logic [6:0]  wr_addr = '0;
    logic [21:0] wr_data = '0;
    logic [7:0]  gate_mask;
    logic        active_bank;
    logic        cnt_err;
    logic        addr_err;

    int checks = 0;
    int errors = 0;
    int sh_mask [128];
    int sh_cnt  [128];

    always #4 clk = ~clk;

    gate_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .global_en(global_en), .port_en(port_en),
        .single_buf(single_buf), .bank_sel(bank_sel), .cycle_start(cycle_start),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .gate_mask(gate_mask), .active_bank(active_bank),
        .cnt_err(cnt_err), .addr_err(addr_err)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // R1: count in bits 21:8, mask in bits 7:0, bank in address bit 6
    task automatic wr(input int bank, input int slot, input int mask, input int cnt);
        wr_en   = 1'b1;
        wr_addr = 7'(bank * 64 + slot);
        wr_data = {14'(cnt), 8'(mask)};
        sh_mask[bank * 64 + slot] = mask & 255;
        sh_cnt[bank * 64 + slot]  = cnt;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Expected outputs k clocks after the cycle-start edge
    function automatic void model(input int bank, input int k,
                                  output int m, output int ae, output int ce);
        int acc = 0;
        m = 0; ae = 0; ce = 0;
        for (int i = 0; i < 64; i++) begin
            int c;
            c = sh_cnt[bank * 64 + i];
            m = sh_mask[bank * 64 + i];
            if (c > 0 && c < 16) ce = 1;
            if (c == 0) return;
            if (k < acc + c) return;
            acc += c;
        end
        ae = 1;
    endfunction

    task automatic pulse();
        cycle_start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cycle_start = 1'b0;
    endtask

    task automatic run(input int bank, input int k0, input int n, input string tag);
        int m, ae, ce;
        for (int k = k0; k < k0 + n; k++) begin
            model(bank, k, m, ae, ce);
            chk(tag, "gate_mask", int'(gate_mask), m);
            chk("R6/R11", "addr_err", int'(addr_err), ae);
            chk("R10/R11", "cnt_err", int'(cnt_err), ce);
            chk("R8", "active_bank", int'(active_bank), bank);
            @(negedge clk);
        end
    endtask

    task automatic expect_open(input int n, input int bank, input string tag);
        for (int k = 0; k < n; k++) begin
            chk(tag, "gate_mask", int'(gate_mask), 255);
            chk(tag, "active_bank", int'(active_bank), bank);
            @(negedge clk);
        end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int total1;
        @(negedge clk);
        @(negedge clk);
        // Reset state
        chk("R2", "reset gate_mask", int'(gate_mask), 255);
        chk("R8", "reset active_bank", int'(active_bank), 0);
        chk("R6", "reset addr_err", int'(addr_err), 0);
        chk("R10", "reset cnt_err", int'(cnt_err), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Bank 0: five timed entries then a zero-count terminator
        for (int i = 0; i < 64; i++) begin
            if (i < 5)       wr(0, i, 1 << i, 16 + 3 * i);
            else if (i == 5) wr(0, i, 8'hA5, 0);
            else             wr(0, i, 8'hFF, 16);
        end
        // Bank 1: all 64 entries timed, so the bank runs out
        total1 = 0;
        for (int i = 0; i < 64; i++) begin
            wr(1, i, i * 37 + 5, 16 + (i % 4));
            total1 += 16 + (i % 4);
        end
        expect_open(5, 0, "R2");

        pulse();
        run(0, 0, 110, "R1,R4");
        run(0, 110, 40, "R5");
        pulse();
        run(0, 0, 30, "R3");
        pulse();
        run(0, 0, 20, "R7");
        bank_sel = 1'b1;
        run(0, 20, 20, "R8");
        pulse();
        run(1, 0, total1 + 20, "R6");
        pulse();
        run(1, 0, 5, "R11");

        // Single-buffer mode ignores the select
        single_buf = 1'b1;
        pulse();
        run(0, 0, 40, "R9");
        single_buf = 1'b0;

        // Short count on the now-idle bank 1
        wr(1, 1, 8'h3C, 3);
        pulse();
        run(1, 0, 60, "R10");
        pulse();
        run(1, 0, 5, "R11");

        // Disabled gating
        bank_sel = 1'b0;
        global_en = 1'b0;
        @(negedge clk);
        pulse();
        expect_open(20, 1, "R2");
        global_en = 1'b1;
        port_en = 1'b0;
        pulse();
        expect_open(20, 1, "R2");
        port_en = 1'b1;
        expect_open(5, 1, "R2");
        pulse();
        run(0, 0, 60, "R3");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule